// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures the time between edges on one of up to sixteen fan tachometer inputs. Every input passes through a two-flop synchroniser and an edge detector. A measurement is started by writing a one-hot trigger word. The set bit names the channel. That channel must be enabled in the control word, and it must map to a valid, enabled measurement type. The channel's 3-bit source index picks a PWM source, and that source's type supplies four settings:

- the power-of-four prescaler for the tach clock;
- the edge mode;
- the 16-bit measurement window;
- the type enable.

A 5-state machine runs the measurement:

- **S_IDLE**: nothing is in progress.
- **S_WAIT_FIRST**: waiting for the first qualifying edge.
- **S_COUNT**: counting divided ticks until the second qualifying edge.
- **S_DONE**: a result is held.
- **S_EXPIRED**: the window ran out.

The transitions are:

- *start* (a valid trigger) goes from any state to S_WAIT_FIRST.
- *reject* (an invalid or zero trigger) goes from any state to S_IDLE.
- *first_edge* goes from S_WAIT_FIRST to S_COUNT.
- *second_edge* goes from S_COUNT to S_DONE.
- *window_out* goes from S_WAIT_FIRST or S_COUNT to S_EXPIRED.
- *abandon* (the channel enable is cleared) goes from S_WAIT_FIRST or S_COUNT to S_IDLE.

Software polls the result word. Bit 31 is the done flag and bits 19:0 hold the number of divided ticks. Fan speed follows as clock·60 / (2·count·divider), and a count of zero means a stopped fan.

Top module: `fan_tach_period_meter`

## Requirements
- R1: After reset the result word is zero and no measurement is in progress.
- R2: Any trigger write, including a write of zero, clears the done flag and the count from the next clock cycle on.
- R3: A measurement starts only when all of the following hold; otherwise the block stays idle with the result zero:
  - the trigger word has exactly one bit set;
  - the enable bit 16+ch of the control word is set;
  - the selected type has its enable bit 0 set;
  - the selected type index is below the number of types (3).
- R4: The channel's source index has three bits. Bits 1:0 come from bits 2ch+1:2ch of the low source word, and bit 2 comes from bit 2ch of the high source word. Source s selects a type index from bits 2s+1:2s of the type map. Type t takes its settings from bits 32t+31:32t of the type configuration bus.
- R5: The 3-bit division field (bits 3:1 of a type word) sets the tick ratio to 4<<(2·div) clocks. The count is the number of ticks within the measured interval. It is reported in result bits 19:0 and saturates at all ones.
- R6: The mode field (bits 5:4) selects the interval: 0 = falling edge to falling edge, 1 = rising edge to rising edge, 2 or 3 = any edge to the next edge.
- R7: Only the triggered channel's input affects a measurement; edges on other inputs are ignored.
- R8: The window is set by bits 31:16 of the type word and counts ticks from the trigger. If it elapses before the interval completes, the done flag stays clear and the count reads zero. A window of zero elapses at the first tick.
- R9: Once done, the result holds without change until the next trigger write, whatever the inputs do.
- R10: Clearing the channel's enable bit during a measurement abandons it, and the done flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tach_in | input | NCH | Raw tachometer inputs |
| ctrl_word | input | 32 | Control; bit 16+ch enables channel ch |
| src_lo_word | input | 2·NCH | Source index bits 1:0 per channel |
| src_hi_word | input | 2·NCH | Source index bit 2 at bit 2ch |
| src_type_map | input | 2·NSRC | Type index per PWM source |
| type_cfg | input | 32·NTYPE | Per-type word: enable, division, mode, window |
| trig_we | input | 1 | Trigger write strobe |
| trig_word | input | NCH | Trigger data, one-hot channel select |
| result_word | output | 32 | Bit 31 done, bits 19:0 count |

## Verification
The assertions watch every cycle for the following:
- the result clears after any trigger write;
- a rejected trigger leaves the machine idle;
- divided ticks are never back to back;
- the count grows by at most one per cycle and never wraps;
- an expiry happens only on a tick;
- a finished result holds until the next trigger.

Only the bench scenarios show the exact tick counts for each mode and prescaler, and the routing from source index through type map to type word. They also show that other inputs are ignored, that the window cuts off a slow fan, and that abandoning a measurement on disable leaves the done flag clear.

// File: rtl/ftach_pkg.sv
package ftach_pkg;
    localparam int DIV_W   = 3;
    localparam int MODE_W  = 2;
    localparam int UNIT_W  = 16;
    localparam int CFG_W   = 32;
    localparam int TIDX_W  = 2;
    localparam int PRE_W   = 2 + 2 * ((1 << DIV_W) - 1);

    localparam logic [MODE_W-1:0] MODE_FALL = 2'd0;
    localparam logic [MODE_W-1:0] MODE_RISE = 2'd1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_FIRST,
        S_COUNT,
        S_DONE,
        S_EXPIRED
    } meas_state_t;

    typedef struct packed {
        logic              en;
        logic [DIV_W-1:0]  div;
        logic [MODE_W-1:0] mode;
        logic [UNIT_W-1:0] unit;
    } type_cfg_t;

    function automatic type_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        type_cfg_t c;
        c.en   = w[0];
        c.div  = w[3:1];
        c.mode = w[5:4];
        c.unit = w[31:16];
        return c;
    endfunction
endpackage

// File: rtl/ftach_sync.sv
module ftach_sync #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] tach_in,
    output logic [NCH-1:0] rise,
    output logic [NCH-1:0] fall
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic meta_q, stab_q, prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= tach_in[g];
                stab_q <= meta_q;
                prev_q <= stab_q;
            end
        end

        assign rise[g] = stab_q & ~prev_q;
        assign fall[g] = ~stab_q & prev_q;
    end
endmodule

// File: rtl/ftach_cfg_sel.sv
module ftach_cfg_sel
    import ftach_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int NSRC  = 8,
    parameter int NTYPE = 3,
    localparam int CH_W  = $clog2(NCH),
    localparam int SRC_W = $clog2(NSRC)
) (
    input  logic [CH_W-1:0]        sel_ch,
    input  logic [2*NCH-1:0]       src_lo_word,
    input  logic [2*NCH-1:0]       src_hi_word,
    input  logic [2*NSRC-1:0]      src_type_map,
    input  logic [NTYPE*CFG_W-1:0] type_cfg,
    output type_cfg_t              cfg,
    output logic                   cfg_ok
);
    logic [SRC_W-1:0]  src_idx;
    logic [TIDX_W-1:0] type_idx;

    always_comb begin
        src_idx  = {src_hi_word[2*sel_ch], src_lo_word[2*sel_ch + 1], src_lo_word[2*sel_ch]};
        type_idx = src_type_map[2*src_idx +: TIDX_W];
        cfg      = '0;
        for (int t = 0; t < NTYPE; t++) begin
            if (type_idx == TIDX_W'(t)) begin
                cfg = unpack_cfg(type_cfg[t*CFG_W +: CFG_W]);
            end
        end
        cfg_ok = (int'(type_idx) < NTYPE) && cfg.en;
    end
endmodule

// File: rtl/ftach_prescaler.sv
module ftach_prescaler
    import ftach_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   limit;

    always_comb begin
        limit = ((PRE_W+1)'(4) << (2 * div)) - (PRE_W+1)'(1);
        tick  = run && ({1'b0, pre_q} == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (restart || tick || !run) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R5
endmodule

// File: rtl/ftach_fsm.sv
module ftach_fsm
    import ftach_pkg::*;
#(
    parameter int CH_W  = 4,
    parameter int CNT_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_we,
    input  logic              start,
    input  logic [CH_W-1:0]   start_ch,
    input  type_cfg_t         start_cfg,
    input  logic              chan_on,
    input  logic              edge_hit,
    input  logic              tick,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  count,
    output logic [CH_W-1:0]   lat_ch,
    output logic [DIV_W-1:0]  lat_div,
    output logic [MODE_W-1:0] lat_mode
);
    meas_state_t       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_sat;
    logic [CNT_W:0]    cnt_sum;
    logic [UNIT_W-1:0] win_q, unit_q;
    logic [UNIT_W:0]   win_next;
    logic              win_out;

    always_comb begin
        cnt_sum  = {1'b0, cnt_q} + (CNT_W+1)'(tick);
        cnt_sat  = cnt_sum[CNT_W] ? '1 : cnt_sum[CNT_W-1:0];
        win_next = {1'b0, win_q} + (UNIT_W+1)'(1);
        win_out  = tick && (win_next >= {1'b0, unit_q});
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_DONE, S_EXPIRED: state_d = state_q;
            S_WAIT_FIRST: begin
                if (!chan_on)      state_d = S_IDLE;
                else if (edge_hit) state_d = S_COUNT;
                else if (win_out)  state_d = S_EXPIRED;
            end
            S_COUNT: begin
                if (!chan_on)      state_d = S_IDLE;
                else if (edge_hit) state_d = S_DONE;
                else if (win_out)  state_d = S_EXPIRED;
            end
            default: state_d = S_IDLE;
        endcase
        if (trig_we) begin
            state_d = start ? S_WAIT_FIRST : S_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            win_q    <= '0;
            unit_q   <= '0;
            lat_ch   <= '0;
            lat_div  <= '0;
            lat_mode <= '0;
        end else if (trig_we) begin
            cnt_q <= '0;
            win_q <= '0;
            if (start) begin
                unit_q   <= start_cfg.unit;
                lat_ch   <= start_ch;
                lat_div  <= start_cfg.div;
                lat_mode <= start_cfg.mode;
            end
        end else if (state_q == S_WAIT_FIRST) begin
            if (tick) win_q <= win_next[UNIT_W-1:0];
            cnt_q <= '0;
        end else if (state_q == S_COUNT) begin
            if (tick) win_q <= win_next[UNIT_W-1:0];
            cnt_q <= cnt_sat;
        end
    end

    always_comb begin
        busy  = (state_q == S_WAIT_FIRST) || (state_q == S_COUNT);
        done  = (state_q == S_DONE);
        count = (state_q == S_DONE) ? cnt_q : '0;
    end

    AST_CLEAR_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        trig_we |=> !done); // R2
    AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_we && !start) |=> (state_q == S_IDLE)); // R3
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE && !trig_we) |=> (state_q == S_DONE) && $stable(cnt_q)); // R9
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COUNT && !trig_we) |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1))); // R5
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COUNT && cnt_q == '1 && !trig_we) |=> (cnt_q == '1)); // R5
    AST_EXPIRE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EXPIRED && $past(state_q) != S_EXPIRED) |-> $past(tick)); // R8
endmodule

// File: rtl/fan_tach_period_meter.sv
module fan_tach_period_meter
    import ftach_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int NSRC  = 8,
    parameter int NTYPE = 3,
    parameter int CNT_W = 20,
    localparam int CH_W   = $clog2(NCH),
    localparam int EN_LSB = 16,
    localparam int DONE_BIT = 31
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         tach_in,
    input  logic [31:0]            ctrl_word,
    input  logic [2*NCH-1:0]       src_lo_word,
    input  logic [2*NCH-1:0]       src_hi_word,
    input  logic [2*NSRC-1:0]      src_type_map,
    input  logic [NTYPE*CFG_W-1:0] type_cfg,
    input  logic                   trig_we,
    input  logic [NCH-1:0]         trig_word,
    output logic [31:0]            result_word
);
    logic [NCH-1:0]    rise, fall;
    logic [CH_W-1:0]   trig_idx, lat_ch;
    logic              trig_single, start, cfg_ok, chan_on, edge_hit, tick, busy, done;
    type_cfg_t         sel_cfg;
    logic [DIV_W-1:0]  lat_div;
    logic [MODE_W-1:0] lat_mode;
    logic [CNT_W-1:0]  count;

    always_comb begin
        trig_single = (trig_word != '0) && ((trig_word & (trig_word - NCH'(1))) == '0);
        trig_idx    = '0;
        for (int c = 0; c < NCH; c++) begin
            if (trig_word[c]) trig_idx = CH_W'(c);
        end
    end

    ftach_sync #(.NCH(NCH)) u_sync (
        .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .rise(rise), .fall(fall)
    );

    ftach_cfg_sel #(.NCH(NCH), .NSRC(NSRC), .NTYPE(NTYPE)) u_cfg (
        .sel_ch(trig_idx), .src_lo_word(src_lo_word), .src_hi_word(src_hi_word),
        .src_type_map(src_type_map), .type_cfg(type_cfg), .cfg(sel_cfg), .cfg_ok(cfg_ok)
    );

    always_comb begin
        start   = trig_we && trig_single && ctrl_word[EN_LSB + int'(trig_idx)] && cfg_ok;
        chan_on = ctrl_word[EN_LSB + int'(lat_ch)];
        if (lat_mode == MODE_FALL)      edge_hit = fall[lat_ch];
        else if (lat_mode == MODE_RISE) edge_hit = rise[lat_ch];
        else                            edge_hit = rise[lat_ch] | fall[lat_ch];
    end

    ftach_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .restart(trig_we), .run(busy), .div(lat_div), .tick(tick)
    );

    ftach_fsm #(.CH_W(CH_W), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .start(start), .start_ch(trig_idx),
        .start_cfg(sel_cfg), .chan_on(chan_on), .edge_hit(edge_hit), .tick(tick),
        .busy(busy), .done(done), .count(count), .lat_ch(lat_ch), .lat_div(lat_div),
        .lat_mode(lat_mode)
    );

    always_comb begin
        result_word            = '0;
        result_word[DONE_BIT]  = done;
        result_word[CNT_W-1:0] = count;
    end

    AST_DONE_NEEDS_COUNT_OR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !result_word[DONE_BIT] |-> (result_word[CNT_W-1:0] == '0)); // R8
endmodule

// File: tb/test_fan_tach_period_meter.sv
module test_fan_tach_period_meter;
    localparam int NCH = 16, NSRC = 8, NTYPE = 3;
    localparam int UNIT = 2000;
    localparam int NVEC = 7;
    // each row: channel, source, period in clocks
    localparam int VEC [NVEC][3] = '{
        '{0, 0, 400}, '{5, 1, 640}, '{15, 2, 1280}, '{7, 3, 48},
        '{9, 4, 320}, '{12, 5, 2560}, '{3, 6, 8}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NCH-1:0] tach_in = '1;
    logic [31:0] ctrl_word = '0;
    logic [2*NCH-1:0] src_lo_word = '0, src_hi_word = '0;
    logic [2*NSRC-1:0] src_type_map = '0;
    logic [NTYPE*32-1:0] type_cfg = '0;
    logic trig_we = 1'b0;
    logic [NCH-1:0] trig_word = '0;
    logic [31:0] result_word;
    int n_cmp = 0, n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fan_tach_period_meter i_fan_tach_period_meter (
        .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .ctrl_word(ctrl_word),
        .src_lo_word(src_lo_word), .src_hi_word(src_hi_word), .src_type_map(src_type_map),
        .type_cfg(type_cfg), .trig_we(trig_we), .trig_word(trig_word), .result_word(result_word)
    );

    function automatic logic [31:0] cfgw(bit en, int div, int mode, int unit);
        return {unit[15:0], 10'd0, mode[1:0], div[2:0], en};
    endfunction

    // type t settings: t0 div0 falling, t1 div1 rising, t2 div2 any edge
    function automatic int type_of(int src);
        return (src == 7) ? 3 : src % 3;
    endfunction
    function automatic int expect_cnt(int src, int p);
        int t = type_of(src);
        int ratio = 4 << (2 * t);
        return (t == 2) ? p / 2 / ratio : p / ratio;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic trig(logic [NCH-1:0] w);
        @(negedge clk); trig_we = 1'b1; trig_word = w;
        @(negedge clk); trig_we = 1'b0; trig_word = '0;
    endtask

    task automatic set_src(int ch, int src);
        src_lo_word[2*ch +: 2] = src[1:0];
        src_hi_word[2*ch]      = src[2];
    endtask

    // falling, rising, falling, rising spaced p/2 apart
    task automatic pulses(int ch, int p);
        cyc(8);
        tach_in[ch] = 1'b0; cyc(p / 2);
        tach_in[ch] = 1'b1; cyc(p / 2);
        tach_in[ch] = 1'b0; cyc(p / 2);
        tach_in[ch] = 1'b1; cyc(10);
    endtask

    task automatic defaults();
        type_cfg = {cfgw(1, 2, 2, UNIT), cfgw(1, 1, 1, UNIT), cfgw(1, 0, 0, UNIT)};
        ctrl_word = 32'hFFFF_0003;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < NSRC; s++) src_type_map[2*s +: 2] = 2'(type_of(s));
        defaults();
        cyc(3);
        chk("R1 reset result", result_word, 32'h0);
        rst_n = 1'b1;
        cyc(5);
        chk("R1 idle after reset", result_word, 32'h0);

        // R4 R5 R6: table of vectors
        for (int v = 0; v < NVEC; v++) begin
            set_src(VEC[v][0], VEC[v][1]);
            trig('0);
            trig(NCH'(1) << VEC[v][0]);
            pulses(VEC[v][0], VEC[v][2]);
            chk($sformatf("R4 R5 R6 vec%0d", v), result_word,
                {1'b1, 11'd0, 20'(expect_cnt(VEC[v][1], VEC[v][2]))});
        end

        // R9: more edges after done do not change the result
        pulses(3, 40);
        chk("R9 hold after done", result_word, {1'b1, 11'd0, 20'd2});
        // R2: zero trigger write clears
        trig('0);
        chk("R2 clear on trigger write", result_word, 32'h0);

        // R3: disabled channel
        set_src(2, 0);
        ctrl_word[16+2] = 1'b0;
        trig(NCH'(1) << 2);
        pulses(2, 40);
        chk("R3 disabled channel", result_word, 32'h0);
        ctrl_word[16+2] = 1'b1;
        // R3: two bits set
        trig(16'h0006);
        pulses(2, 40);
        chk("R3 non one-hot trigger", result_word, 32'h0);
        // R3: type disabled
        type_cfg[0] = 1'b0;
        trig(NCH'(1) << 2);
        pulses(2, 40);
        chk("R3 type disabled", result_word, 32'h0);
        defaults();
        // R4: source 7 maps to type index 3 which does not exist
        set_src(2, 7);
        trig(NCH'(1) << 2);
        pulses(2, 40);
        chk("R4 invalid type index", result_word, 32'h0);

        // R7: other channel edges ignored
        set_src(4, 0);
        trig(NCH'(1) << 4);
        pulses(6, 40);
        chk("R7 other channel ignored", result_word, 32'h0);
        pulses(4, 40);
        chk("R7 own channel measured", result_word, {1'b1, 11'd0, 20'd10});

        // R8: short window
        type_cfg[31:16] = 16'd5;
        set_src(0, 0);
        trig(NCH'(1) << 0);
        pulses(0, 200);
        chk("R8 window expired", result_word, 32'h0);
        type_cfg[31:16] = 16'd0;
        trig(NCH'(1) << 0);
        pulses(0, 40);
        chk("R8 zero window", result_word, 32'h0);
        defaults();

        // R10: disable mid-measurement
        set_src(1, 0);
        trig(NCH'(1) << 1);
        cyc(8);
        tach_in[1] = 1'b0; cyc(20);
        ctrl_word[16+1] = 1'b0; cyc(2);
        ctrl_word[16+1] = 1'b1;
        tach_in[1] = 1'b1; cyc(20);
        tach_in[1] = 1'b0; cyc(20);
        tach_in[1] = 1'b1; cyc(10);
        chk("R10 abandoned on disable", result_word, 32'h0);

        // R2: valid trigger after a done result clears it
        set_src(1, 0);
        trig(NCH'(1) << 1);
        pulses(1, 40);
        chk("R5 re-measure", result_word, {1'b1, 11'd0, 20'd10});
        trig(NCH'(1) << 1);
        chk("R2 new trigger clears", result_word, 32'h0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule